// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised register, eight bits wide by default, that can hold its contents, shift toward the high end, shift toward the low end, or take a parallel word from a shared bus. A two-bit mode input, sampled only on the rising clock edge, selects the operation. The parallel port is meant for a shared bus. The block reports its register value and a drive-enable. A wrapper or the surrounding fabric then resolves the line to high impedance when the enable is low. During a load, the word on the bus, driven from outside, is captured.

Two serial taps expose the lowest and highest register bits at all times. They are never disabled, so several instances can be chained into a longer word. The low instance's high tap feeds the next instance's right-shift input, and the high instance's low tap feeds back into the low instance's left-shift input. An active-low reset clears the register at once, without waiting for a clock. Two active-low enables gate the bus drive. Either enable being high turns the drive off, and so does the load mode. None of this stops the register from operating.

The operating states are the four modes: HOLD (mode 00), SHIFT-RIGHT (01), SHIFT-LEFT (10) and LOAD (11). Any mode can follow any other on the next edge, and reset forces the cleared state from any mode.

Top module: `ushift_bidir`

## Requirements
- R1: With mode 11 (LOAD), a rising edge copies bus_in into the register, and bus_out shows it after that edge.
- R2: With mode 01 (SHIFT-RIGHT), a rising edge moves each bit n to bit n+1 and places ser_r_in in bit 0.
- R3: With mode 10 (SHIFT-LEFT), a rising edge moves each bit n to bit n-1 and places ser_l_in in the top bit (bit W-1).
- R4: With mode 00 (HOLD), a rising edge leaves the register unchanged, whatever ser_r_in, ser_l_in and bus_in carry.
- R5: rst_n low clears every register bit immediately, with no clock edge needed, and holds it at zero while low, whatever the mode.
- R6: bus_oe is 0 whenever oe_a_n or oe_b_n is 1.
- R7: bus_oe is 0 whenever mode is 11. When both enables are 0 and mode is not 11, bus_oe is 1.
- R8: Load, shift and hold act on the register exactly as in R1 to R4 while bus_oe is 0.
- R9: tap_lo always equals register bit 0 and tap_hi always equals bit W-1, independent of the enables and the mode.
- R10: The first rising edge after rst_n goes high performs the selected mode normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| oe_a_n | input | 1 | Active-low bus drive enable A |
| oe_b_n | input | 1 | Active-low bus drive enable B |
| ser_r_in | input | 1 | Serial bit entering bit 0 on shift right |
| ser_l_in | input | 1 | Serial bit entering bit W-1 on shift left |
| bus_in | input | W | Value present on the shared bus |
| bus_out | output | W | Register value offered to the bus |
| bus_oe | output | 1 | High when the block drives the bus |
| tap_lo | output | 1 | Register bit 0, always valid |
| tap_hi | output | 1 | Register bit W-1, always valid |

## Verification
The bench loads every 8-bit value through the bus. A design that swapped the mode decode or latched the bus a cycle late shows the wrong word here. Shift sweeps across many seed words catch a reversed shift direction, and they also catch a serial input entering at the wrong end, which would show up on the taps. A sweep over all enable and mode combinations catches a design that drives the bus during a load and so fights the external driver. A reset applied mid-cycle with no clock catches a reset that waits for an edge. Two chained instances shift a 16-bit word both ways and expose any tap that goes idle or is taken from the wrong bit.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        MD_HOLD = 2'b00,
        MD_SHR  = 2'b01,
        MD_SHL  = 2'b10,
        MD_LOAD = 2'b11
    } mode_e;

endpackage

// File: rtl/ushift_next.sv
module ushift_next
    import ushift_pkg::*;
#(
    parameter int W = 8
) (
    input  mode_e          md,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   par_in,
    input  logic           sr_bit,
    input  logic           sl_bit,
    output logic [W-1:0]   nxt
);

    always_comb begin
        unique case (md)
            MD_HOLD: nxt = cur;
            MD_SHR:  nxt = {cur[W-2:0], sr_bit};
            MD_SHL:  nxt = {sl_bit, cur[W-1:1]};
            MD_LOAD: nxt = par_in;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/ushift_drive.sv
module ushift_drive
    import ushift_pkg::*;
(
    input  mode_e md,
    input  logic  en_a_n,
    input  logic  en_b_n,
    output logic  drive
);

    logic gated_off;

    always_comb begin
        gated_off = en_a_n | en_b_n;
        unique case (md)
            MD_LOAD: drive = 1'b0;
            MD_HOLD,
            MD_SHR,
            MD_SHL:  drive = ~gated_off;
            default: drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/ushift_bidir.sv
module ushift_bidir
    import ushift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_oe,
    output logic         tap_lo,
    output logic         tap_hi
);

    localparam int TOP = W - 1;

    mode_e        md;
    logic [W-1:0] cells;
    logic [W-1:0] cells_nxt;
    logic         drv;

    assign md = mode_e'(mode);

    ushift_next #(.W(W)) u_next (
        .md     (md),
        .cur    (cells),
        .par_in (bus_in),
        .sr_bit (ser_r_in),
        .sl_bit (ser_l_in),
        .nxt    (cells_nxt)
    );

    ushift_drive u_drive (
        .md     (md),
        .en_a_n (oe_a_n),
        .en_b_n (oe_b_n),
        .drive  (drv)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else begin
            cells <= cells_nxt;
        end
    end

    // outputs
    always_comb begin
        bus_out = cells;
        bus_oe  = drv;
        tap_lo  = cells[0];
        tap_hi  = cells[TOP];
    end

endmodule

// File: rtl/ushift_bidir_chk.sv
module ushift_bidir_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic         oe_a_n,
    input logic         oe_b_n,
    input logic         ser_r_in,
    input logic         ser_l_in,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         tap_lo,
    input logic         tap_hi
);

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (bus_out == $past(bus_in)));

    a_r2_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (bus_out == {$past(bus_out[W-2:0]), $past(ser_r_in)}));

    a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (bus_out == {$past(ser_l_in), $past(bus_out[W-1:1])}));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(bus_out));

    a_r6_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !bus_oe);

    a_r7_load_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> !bus_oe);

    a_r7_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && mode != 2'b11) |-> bus_oe);

    a_r9_taps: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_lo == bus_out[0]) && (tap_hi == bus_out[W-1]));

    always @(negedge clk) begin
        if (!rst_n) begin
            a_r5_reset_clear: assert (bus_out == '0);
        end
    end

endmodule

bind ushift_bidir ushift_bidir_chk #(.W(W)) u_chk (.*);

// File: tb/ushift_bidir_tb.sv
module ushift_bidir_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         oe_a_n = 1'b0;
    logic         oe_b_n = 1'b0;
    logic         sr_in = 1'b0;
    logic         sl_in = 1'b0;
    logic [W-1:0] ext_lo = '0;
    logic [W-1:0] ext_hi = '0;
    logic         casc = 1'b0;

    logic [W-1:0] lo_out, hi_out, lo_bus, hi_bus;
    logic         lo_oe, hi_oe, lo_tl, lo_th, hi_tl, hi_th;
    logic         lo_sl, hi_sr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign lo_bus = lo_oe ? lo_out : ext_lo;
    assign hi_bus = hi_oe ? hi_out : ext_hi;
    assign lo_sl  = casc ? hi_tl : sl_in;
    assign hi_sr  = casc ? lo_th : sr_in;

    ushift_bidir #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_r_in(sr_in), .ser_l_in(lo_sl), .bus_in(lo_bus),
        .bus_out(lo_out), .bus_oe(lo_oe), .tap_lo(lo_tl), .tap_hi(lo_th)
    );

    ushift_bidir #(.W(W)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .mode(mode), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_r_in(hi_sr), .ser_l_in(sl_in), .bus_in(hi_bus),
        .bus_out(hi_out), .bus_oe(hi_oe), .tap_lo(hi_tl), .tap_hi(hi_th)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] md, input logic sr, input logic sl, input logic [W-1:0] d);
        mode = md; sr_in = sr; sl_in = sl; ext_lo = d;
        @(posedge clk); #1;
    endtask

    task automatic chk_state(input string tag, input logic [W-1:0] m);
        chk(tag, {8'h0, lo_out}, {8'h0, m});
        chk("R9 taps", {14'h0, lo_th, lo_tl}, {14'h0, m[W-1], m[0]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] m;
        logic [15:0]  w;
        #2 rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R5 reset state", {8'h0, lo_out}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        m = '0;

        // R10: first edge after release shifts right with a 1
        step(2'b01, 1'b1, 1'b0, 8'h00);
        m = 8'h01;
        chk_state("R10 first edge", m);

        // R1 exhaustive load, R7 drive off during load
        for (int v = 0; v < 256; v++) begin
            step(2'b11, v[0], v[1], v[7:0]);
            m = v[7:0];
            chk_state("R1 load", m);
            chk("R7 load undriven", {15'h0, lo_oe}, 16'h0);
        end

        // R2 shift right sweep
        for (int v = 0; v < 256; v += 15) begin
            step(2'b11, 1'b0, 1'b0, v[7:0]);
            m = v[7:0];
            for (int k = 0; k < 9; k++) begin
                logic b;
                b = ((v * 7) >> k) & 1;
                step(2'b01, b, ~b, ~v[7:0]);
                m = {m[W-2:0], b};
                chk_state("R2 shift right", m);
            end
        end

        // R3 shift left sweep
        for (int v = 0; v < 256; v += 15) begin
            step(2'b11, 1'b0, 1'b0, v[7:0]);
            m = v[7:0];
            for (int k = 0; k < 9; k++) begin
                logic b;
                b = ((v * 5 + 3) >> k) & 1;
                step(2'b10, ~b, b, ~v[7:0]);
                m = {b, m[W-1:1]};
                chk_state("R3 shift left", m);
            end
        end

        // R4 hold with busy inputs
        for (int v = 1; v < 256; v += 37) begin
            step(2'b11, 1'b0, 1'b0, v[7:0]);
            m = v[7:0];
            for (int k = 0; k < 4; k++) begin
                step(2'b00, k[0], ~k[0], ~v[7:0] + k[7:0]);
                chk_state("R4 hold", m);
            end
        end

        // R6/R7 enable and mode sweep
        for (int c = 0; c < 16; c++) begin
            logic exp_oe;
            mode = c[1:0]; oe_a_n = c[2]; oe_b_n = c[3];
            #1;
            exp_oe = !(c[2] || c[3]) && (c[1:0] != 2'b11);
            chk(c[3:2] != 2'b00 ? "R6 enable gating" : "R7 mode gating", {15'h0, lo_oe}, {15'h0, exp_oe});
            @(posedge clk); #1;
            m = lo_out;
        end
        oe_a_n = 1'b0; oe_b_n = 1'b0;

        // R8 operation with drivers off
        oe_b_n = 1'b1;
        step(2'b11, 1'b0, 1'b0, 8'hA5); m = 8'hA5;
        chk_state("R8 load while off", m);
        step(2'b01, 1'b1, 1'b0, 8'h00); m = {m[W-2:0], 1'b1};
        chk_state("R8 shr while off", m);
        step(2'b10, 1'b0, 1'b0, 8'h00); m = {1'b0, m[W-1:1]};
        chk_state("R8 shl while off", m);
        step(2'b00, 1'b1, 1'b1, 8'hFF);
        chk_state("R8 hold while off", m);
        chk("R6 still off", {15'h0, lo_oe}, 16'h0);
        oe_b_n = 1'b0;
        step(2'b00, 1'b0, 1'b0, 8'h00);
        chk("R7 drives when enabled", {8'h0, lo_bus}, {8'h0, m});

        // R5 asynchronous reset mid-cycle, load requested
        step(2'b11, 1'b0, 1'b0, 8'h7E);
        mode = 2'b11; ext_lo = 8'hFF;
        #2 rst_n = 1'b0;
        #1;
        chk("R5 async clear", {8'h0, lo_out}, 16'h0);
        @(posedge clk); #1;
        chk("R5 overrides load", {8'h0, lo_out}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2'b10, 1'b0, 1'b1, 8'h00);
        chk_state("R10 shl after release", 8'h80);

        // cascade: 16-bit shift both directions (R2, R3, R9)
        ext_hi = 8'hC3;
        step(2'b11, 1'b0, 1'b0, 8'h3C);
        w = 16'hC33C;
        chk("R1 cascade load", {hi_out, lo_out}, w);
        casc = 1'b1;
        for (int k = 0; k < 16; k++) begin
            logic b;
            b = (16'h9B2D >> k) & 1;
            step(2'b01, b, 1'b0, 8'h00);
            w = {w[14:0], b};
            chk("R2 R9 cascade right", {hi_out, lo_out}, w);
        end
        for (int k = 0; k < 16; k++) begin
            logic b;
            b = (16'h5A71 >> k) & 1;
            step(2'b10, 1'b0, b, 8'h00);
            w = {b, w[15:1]};
            chk("R3 R9 cascade left", {hi_out, lo_out}, w);
        end
        casc = 1'b0;

        finish_run();
    end

endmodule